// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a CPU interrupt once a programmed number of video scanlines have gone by. Software loads a line count into a holding register and can ask for that count to be reloaded into the live counter. It can also arm the interrupt, or disarm it, which also acknowledges the interrupt. A separate detector, outside this block, produces a one-cycle pulse for each scanline. On each pulse the counter either reloads from the holding register or counts down by one.

The interrupt request is a level. It rises on the pulse that takes the counter from a nonzero value to zero while the block is armed. It stays high until software disarms the block or reset is applied. When a reload puts a zero into a counter that was already zero, no interrupt is produced.

All four register writes share one write strobe and a 2-bit select. A write and a scanline pulse can arrive in the same cycle. In that case the write takes effect first, and the pulse then acts on the updated state.

Top module: `scanIrqCounter`

## Requirements
- R1: After reset the counter, the holding register and the arm flag are all zero and irqOut is low. Scanline pulses after reset, with no reload value written, never raise irqOut, even once armed.
- R2: A write with wrSel=0 stores wrData into the holding register with bit 0 forced to 0, so writing 5 behaves exactly like writing 4.
- R3: A write with wrSel=1 marks a reload as pending and leaves the counter unchanged. The next scanline pulse loads the holding register into the counter and clears the pending mark.
- R4: A scanline pulse that finds the counter at zero loads the holding register.
- R5: A scanline pulse that finds the counter nonzero, with no reload pending, decrements the counter by one.
- R6: irqOut goes high one clock after a scanline pulse that takes the counter from nonzero to zero while armed. This includes a pending reload of a zero holding value into a nonzero counter.
- R7: While disarmed, a counter reaching zero does not raise irqOut.
- R8: Once high, irqOut stays high through further scanline pulses until a disarm write or reset.
- R9: A write with wrSel=2 disarms the block and drives irqOut low on the next clock.
- R10: A write with wrSel=3 arms the block.
- R11: When a write and a scanline pulse fall in the same cycle, the pulse sees the state after the write. This covers the new holding value, a reload just requested, and the arm flag just set or cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 holding value, 1 reload, 2 disarm/acknowledge, 3 arm |
| wrData | input | CNT_W | Write data (used only by the holding-value write) |
| lineTick | input | 1 | One-cycle pulse per scanline |
| irqOut | output | 1 | Interrupt request, active high, sticky |

## Verification
A register write and a scanline pulse can land in the same clock, and the bench drives that case for each kind of write. A holding-value write together with a pulse at zero count must load the new value. A reload request together with a pulse must reload rather than decrement. An arm write together with the final pulse must fire at once, and a disarm write together with the final pulse must stay quiet. Each case is judged only from the cycle in which irqOut rises, or fails to rise, on the ticks that follow. Had the wrong ordering been applied, irqOut would move one or more ticks away from that cycle.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  typedef enum logic [1:0] {
    SEL_LATCH   = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_DISABLE = 2'd2,
    SEL_ENABLE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic latchWr;
    logic cntLoad;
    logic cntDec;
  } dpStrobe_t;

endpackage

// File: rtl/scan_irq_datapath.sv
module scan_irq_datapath
  import scan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countQ,
  output logic             countZero,
  output logic             hitZero
);

  localparam logic [CNT_W-1:0] EVEN_MASK = ~CNT_W'(1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] latchQ;
  logic [CNT_W-1:0] latchNext;
  logic [CNT_W-1:0] countNext;

  // Holding value: the write lands first, so a same-cycle load sees it.
  always_comb begin
    latchNext = latchQ;
    if (strobe.latchWr) latchNext = wrData & EVEN_MASK;
  end

  always_comb begin
    countNext = countQ;
    if (strobe.cntLoad)     countNext = latchNext;
    else if (strobe.cntDec) countNext = countQ - ONE;
  end

  assign countZero = (countQ == '0);
  assign hitZero   = (strobe.cntLoad | strobe.cntDec) & ~countZero & (countNext == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      countQ <= '0;
    end else begin
      latchQ <= latchNext;
      countQ <= countNext;
    end
  end

endmodule

// File: rtl/scan_irq_ctrl.sv
module scan_irq_ctrl
  import scan_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic [1:0] wrSel,
  input  logic      lineTick,
  input  logic      countZero,
  input  logic      hitZero,
  output dpStrobe_t strobe,
  output logic      enableQ,
  output logic      reloadPend,
  output logic      irqQ
);

  logic wrLatch, wrReload, wrDisable, wrEnable;
  logic reloadEff, enableEff;

  assign wrLatch   = wrEn && (wrSel == SEL_LATCH);
  assign wrReload  = wrEn && (wrSel == SEL_RELOAD);
  assign wrDisable = wrEn && (wrSel == SEL_DISABLE);
  assign wrEnable  = wrEn && (wrSel == SEL_ENABLE);

  // Write-before-tick: effective values include this cycle's write.
  assign reloadEff = reloadPend | wrReload;

  always_comb begin
    enableEff = enableQ;
    if (wrEnable)       enableEff = 1'b1;
    else if (wrDisable) enableEff = 1'b0;
  end

  always_comb begin
    strobe.latchWr = wrLatch;
    strobe.cntLoad = lineTick & (countZero | reloadEff);
    strobe.cntDec  = lineTick & ~countZero & ~reloadEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ    <= 1'b0;
      reloadPend <= 1'b0;
      irqQ       <= 1'b0;
    end else begin
      enableQ    <= enableEff;
      reloadPend <= lineTick ? 1'b0 : reloadEff;
      irqQ       <= (irqQ & ~wrDisable) | (hitZero & enableEff);
    end
  end

endmodule

// File: rtl/scanIrqCounter.sv
module scanIrqCounter
  import scan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             lineTick,
  output logic             irqOut
);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] countQ;
  logic             countZero;
  logic             hitZero;
  logic             enableQ;
  logic             reloadPend;

  scan_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .lineTick   (lineTick),
    .countZero  (countZero),
    .hitZero    (hitZero),
    .strobe     (strobe),
    .enableQ    (enableQ),
    .reloadPend (reloadPend),
    .irqQ       (irqOut)
  );

  scan_irq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .countQ    (countQ),
    .countZero (countZero),
    .hitZero   (hitZero)
  );

endmodule

// File: rtl/scan_irq_checker.sv
module scan_irq_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic             lineTick,
  input logic             irqOut,
  input logic [CNT_W-1:0] countQ,
  input logic             enableQ,
  input logic             reloadPend
);

  assert_rise_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(lineTick));

  assert_rise_needs_arm_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(enableQ || (wrEn && wrSel == 2'd3)));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(wrEn && wrSel == 2'd2)) |=> irqOut);

  assert_disarm_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2) |=> !irqOut);

  assert_reload_defers_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1 && !lineTick) |=> $stable(countQ));

  assert_tick_decrements_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lineTick && countQ != '0 && !reloadPend && !(wrEn && wrSel == 2'd1))
      |=> (countQ == $past(countQ) - CNT_W'(1)));

endmodule

bind scanIrqCounter scan_irq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .lineTick   (lineTick),
  .irqOut     (irqOut),
  .countQ     (countQ),
  .enableQ    (enableQ),
  .reloadPend (reloadPend)
);

// File: tb/scanIrqCounter_tb.sv
module scanIrqCounter_tb;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrSel = 2'd0;
  logic [CNT_W-1:0] wrData = '0;
  logic             lineTick = 1'b0;
  logic             irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #10 clk = ~clk;

  scanIrqCounter #(.CNT_W(CNT_W)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .lineTick (lineTick),
    .irqOut   (irqOut)
  );

  // Monitor: each queued item belongs to the edge that follows its push.
  always @(posedge clk) begin
    #2;
    if (scoreQ.size() > 0) begin
      expItem_t it;
      it = scoreQ.pop_front();
      checks++;
      if (irqOut !== it.exp) begin
        fails++;
        $display("FAIL %s: irqOut=%0b expected=%0b", it.tag, irqOut, it.exp);
      end
    end
  end

  // Driver: sets inputs at the falling edge and records the expected irqOut.
  task automatic step(input bit we, input logic [1:0] sel, input logic [CNT_W-1:0] dat,
                      input bit tick, input bit exp, input string tag);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = dat; lineTick = tick;
    scoreQ.push_back('{exp, tag});
  endtask

  task automatic tick(input bit exp, input string tag);
    step(1'b0, 2'd0, '0, 1'b1, exp, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [CNT_W-1:0] dat, input bit exp,
                    input string tag);
    step(1'b1, sel, dat, 1'b0, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 2'd0, '0, 1'b0, 1'b0, "R1 reset state");
    // R1: armed, but counter and holding value are zero after reset
    wr(2'd3, '0, 1'b0, "R1 arm");
    for (int i = 0; i < 3; i++) tick(1'b0, "R1 no fire from reset state");
    // R2, R4, R5, R6: holding 5 acts as 4
    wr(2'd0, 8'd5, 1'b0, "R2 latch write");
    wr(2'd1, '0, 1'b0, "R3 reload request");
    tick(1'b0, "R4 load on tick");
    tick(1'b0, "R5 count 3");
    tick(1'b0, "R5 count 2");
    tick(1'b0, "R2 count 1, bit0 cleared");
    tick(1'b1, "R6 fire at zero");
    // R8 sticky
    tick(1'b1, "R8 sticky after reload");
    tick(1'b1, "R8 sticky count 3");
    // R9, R7
    wr(2'd2, '0, 1'b0, "R9 disarm clears");
    tick(1'b0, "R7 count 2");
    tick(1'b0, "R7 count 1");
    tick(1'b0, "R7 zero while disarmed");
    // R10
    wr(2'd3, '0, 1'b0, "R10 arm");
    tick(1'b0, "R10 load 4");
    tick(1'b0, "R10 count 3");
    tick(1'b0, "R10 count 2");
    tick(1'b0, "R10 count 1");
    tick(1'b1, "R10 fire when armed");
    // R3: reload mid-count reloads instead of decrementing
    wr(2'd2, '0, 1'b0, "R9 ack");
    wr(2'd0, 8'd6, 1'b0, "R3 latch 6");
    wr(2'd3, '0, 1'b0, "R3 arm");
    tick(1'b0, "R3 load 6");
    tick(1'b0, "R3 count 5");
    wr(2'd1, '0, 1'b0, "R3 reload pending");
    tick(1'b0, "R3 reload to 6");
    for (int i = 0; i < 5; i++) tick(1'b0, "R3 count down from 6");
    tick(1'b1, "R3 fire six ticks after reload");
    // R11: latch write with tick at zero count
    wr(2'd2, '0, 1'b0, "R9 ack");
    step(1'b1, 2'd0, 8'd2, 1'b1, 1'b0, "R11 latch+tick loads new value");
    wr(2'd3, '0, 1'b0, "R11 arm");
    tick(1'b0, "R11 count 1");
    tick(1'b1, "R11 fire from new latch");
    // R11: arm with final tick
    wr(2'd2, '0, 1'b0, "R9 ack");
    tick(1'b0, "R11 load 2");
    tick(1'b0, "R11 count 1");
    step(1'b1, 2'd3, '0, 1'b1, 1'b1, "R11 arm+tick fires");
    // R11: disarm with final tick
    tick(1'b1, "R8 load 2 sticky");
    tick(1'b1, "R8 count 1 sticky");
    step(1'b1, 2'd2, '0, 1'b1, 1'b0, "R11 disarm+tick stays low");
    // R11: reload with tick reloads rather than decrements
    wr(2'd3, '0, 1'b0, "R10 arm");
    tick(1'b0, "R11 load 2");
    step(1'b1, 2'd1, '0, 1'b1, 1'b0, "R11 reload+tick back to 2");
    tick(1'b0, "R11 count 1");
    tick(1'b1, "R11 fire after reload+tick");
    // R6: pending reload of zero into nonzero counter fires
    wr(2'd2, '0, 1'b0, "R9 ack");
    wr(2'd0, 8'd4, 1'b0, "R6 latch 4");
    wr(2'd3, '0, 1'b0, "R6 arm");
    tick(1'b0, "R6 load 4");
    wr(2'd0, 8'd0, 1'b0, "R6 latch 0");
    wr(2'd1, '0, 1'b0, "R6 reload");
    tick(1'b1, "R6 nonzero reloaded to zero fires");
    step(1'b0, 2'd0, '0, 1'b0, 1'b1, "R8 idle sticky");
    @(negedge clk);
    wrEn = 1'b0; lineTick = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule